// File: doc/BRIEF.md
# Configuration Stream Clock-Ratio Detector

This block watches a 32-bit configuration data stream while it flows into a configuration port. The stream's own header states whether the image is encrypted and whether it is compressed. The block counts accepted words from the start of each image and picks up those two properties from two fixed word positions. It then combines them with the configuration bus width, 16 or 32 bits, to produce the 2-bit clock-to-data ratio code. The port logic downstream uses that code to pace its clock against the data. The block never changes, stalls or forwards the stream. It only looks at it.

An image begins with a one-cycle start pulse. The pulse clears the previous result and samples the width select. When the compression word has been accepted, the ratio code is registered and a valid flag rises. If the end-of-image strobe arrives before that word, the block raises a sticky error instead. The next start pulse clears both the error and the result.

Top module: `cfgr_ratio_detect`

## Requirements
- R1: During reset and afterwards until the first start pulse, `ratio_vld_o`, `short_err_o` and `ratio_o` are all 0. Stream words and end strobes seen while no image is open have no effect on them.
- R2: A start pulse clears `ratio_vld_o` and `short_err_o`, restarts the word index at 0 and samples `wide_i` (1 = 32-bit bus, 0 = 16-bit bus). A word presented in the same cycle as the start pulse is not counted.
- R3: Only cycles with `word_vld_i` high advance the word index. The image counts as encrypted when bits [3:2] of word index 69 (counting from 0) are not both zero.
- R4: The image counts as compressed when bit 1 of word index 229 is 0.
- R5: In 16-bit mode the code is 0 (x1) with neither property, 1 (x2) for encryption alone, and 2 (x4) for compression with or without encryption.
- R6: In 32-bit mode every code other than 0 is one higher than in R5. Encryption alone gives 2 (x4), and compression gives 3 (x8). With neither property the code stays 0.
- R7: `ratio_vld_o` rises in the cycle after word 229 is accepted. It holds, and `ratio_o` stays unchanged, until the next start pulse, whatever words follow.
- R8: If `end_i` arrives while an image is open and before word 229 has been accepted, `short_err_o` rises in the next cycle. It stays high until the next start pulse, and `ratio_vld_o` stays 0.
- R9: An `end_i` in the same cycle as word 229, or any `end_i` after it, raises no error.
- R10: Changing `wide_i` while an image is open has no effect on that image's code.
- R11: The contents of words other than 69 and 229 have no effect on the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | One-cycle pulse opening a new image |
| wide_i | input | 1 | Bus width select, sampled at start: 1 = 32-bit, 0 = 16-bit |
| word_vld_i | input | 1 | Stream word valid strobe |
| word_i | input | 32 | Stream word |
| end_i | input | 1 | End-of-image strobe |
| ratio_o | output | 2 | Clock-to-data ratio code: 0 x1, 1 x2, 2 x4, 3 x8 |
| ratio_vld_o | output | 1 | Ratio code valid for the current image |
| short_err_o | output | 1 | Sticky error: image ended before the header was complete |

## Verification
The assertions watch several properties on every cycle. The index never passes the compression word, and the image closes once that word is taken. Valid and error never rise together, and both stay sticky between starts. The sampled width and the encryption flag move only at their own events. Every valid code also lies in the range its width allows. Whether the right words were picked, and whether the code matches the header, can only be shown by the bench's scenarios. These cover every combination of width, encryption field and compression bit, with decoy words around the header positions. They also cover stalled streams, short images ended at two different points, an end strobe coinciding with the last header word, and a width change in the middle of an image.

// File: rtl/cfgr_pkg.sv
// Shared types for the configuration clock-ratio detector.
package cfgr_pkg;
    // Clock-to-data ratio codes, as decoded by the configuration port.
    typedef enum logic [1:0] {
        RATIO_X1 = 2'd0,
        RATIO_X2 = 2'd1,
        RATIO_X4 = 2'd2,
        RATIO_X8 = 2'd3
    } ratio_e;
endpackage

// File: rtl/cfgr_word_index.sv
// Word index tracker.
// Opens an image on start, counts accepted words and flags the two header
// positions. The image closes after the compression word or on an end strobe.
// Assumes ENC_IDX < CMP_IDX. A start pulse overrides all other inputs in its cycle.
module cfgr_word_index #(
    parameter int ENC_IDX = 69,
    parameter int CMP_IDX = 229
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic word_vld_i,
    input  logic end_i,
    output logic hit_enc_o,
    output logic hit_cmp_o,
    output logic early_end_o
);
    localparam int IDX_W = $clog2(CMP_IDX + 1);
    localparam logic [IDX_W-1:0] ENC_POS = IDX_W'(ENC_IDX);
    localparam logic [IDX_W-1:0] CMP_POS = IDX_W'(CMP_IDX);

    logic             open_q;
    logic [IDX_W-1:0] idx_q;
    logic             take;

    assign take        = open_q && word_vld_i && !start_i;
    assign hit_enc_o   = take && (idx_q == ENC_POS);
    assign hit_cmp_o   = take && (idx_q == CMP_POS);
    assign early_end_o = open_q && end_i && !start_i && !hit_cmp_o;

    // Track whether an image is open and the index of the next word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q <= 1'b0;
            idx_q  <= '0;
        end else if (start_i) begin
            open_q <= 1'b1;
            idx_q  <= '0;
        end else begin
            if (take && idx_q != CMP_POS)
                idx_q <= idx_q + 1'b1;
            if (hit_cmp_o || early_end_o)
                open_q <= 1'b0;
        end
    end

    assert_idx_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= CMP_POS);
    assert_close_after_cmp_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_cmp_o |=> !open_q);
    assert_idle_on_vld_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!word_vld_i && !start_i) |=> $stable(idx_q));
endmodule

// File: rtl/cfgr_field_capture.sv
// Header field capture.
// Samples the width select at start. Takes the encryption field from the word
// flagged by the index tracker. Supplies the compression decision straight
// from the live word, for the cycle in which the compression word is flagged.
// Assumes the hit strobes come from cfgr_word_index.
module cfgr_field_capture #(
    parameter int DATA_W  = 32,
    parameter int ENC_LSB = 2,
    parameter int ENC_W   = 2,
    parameter int CMP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic              hit_enc_i,
    input  logic [DATA_W-1:0] word_i,
    output logic              enc_o,
    output logic              cmp_now_o,
    output logic              wide_o
);
    logic enc_q;
    logic wide_q;
    logic enc_field_nz;

    assign enc_field_nz = |word_i[ENC_LSB +: ENC_W];
    assign cmp_now_o    = ~word_i[CMP_BIT];
    assign enc_o        = enc_q;
    assign wide_o       = wide_q;

    // Latch the bus width once per image.
    always_ff @(posedge clk) begin
        if (!rst_n)
            wide_q <= 1'b0;
        else if (start_i)
            wide_q <= wide_i;
    end

    // Record whether the encryption field was nonzero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            enc_q <= 1'b0;
        else if (start_i)
            enc_q <= 1'b0;
        else if (hit_enc_i)
            enc_q <= enc_field_nz;
    end

    assert_width_held_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i |=> $stable(wide_q));
    assert_enc_only_on_hit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!start_i && !hit_enc_i) |=> $stable(enc_q));
endmodule

// File: rtl/cfgr_ratio_encode.sv
// Ratio code encoder.
// Pure combinational mapping from encryption, compression and width to the
// 2-bit ratio code. No state is kept here.
module cfgr_ratio_encode
    import cfgr_pkg::*;
(
    input  logic   enc_i,
    input  logic   cmp_i,
    input  logic   wide_i,
    output ratio_e code_o
);
    ratio_e base;

    // Pick the 16-bit code, then step it up once for the wide bus.
    always_comb begin
        if (cmp_i)
            base = RATIO_X4;
        else if (enc_i)
            base = RATIO_X2;
        else
            base = RATIO_X1;
        if (wide_i && base != RATIO_X1)
            code_o = ratio_e'(base + 2'd1);
        else
            code_o = base;
    end
endmodule

// File: rtl/cfgr_result.sv
// Result holder.
// Registers the code when the compression word is taken and raises a
// sticky error when an image ends early. A start pulse clears both.
module cfgr_result
    import cfgr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start_i,
    input  logic       hit_cmp_i,
    input  logic       early_end_i,
    input  ratio_e     code_i,
    output logic [1:0] ratio_o,
    output logic       vld_o,
    output logic       err_o
);
    ratio_e ratio_q;
    logic   vld_q;
    logic   err_q;

    assign ratio_o = ratio_q;
    assign vld_o   = vld_q;
    assign err_o   = err_q;

    // Hold the ratio code and its valid flag per image.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            ratio_q <= RATIO_X1;
            vld_q   <= 1'b0;
        end else if (hit_cmp_i) begin
            ratio_q <= code_i;
            vld_q   <= 1'b1;
        end
    end

    // Sticky short-image error.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i)
            err_q <= 1'b0;
        else if (early_end_i)
            err_q <= 1'b1;
    end

    assert_excl_vld_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(vld_q && err_q));
    assert_vld_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_q && !start_i) |=> (vld_q && $stable(ratio_q)));
    assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && !start_i) |=> err_q);
    assert_start_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (!vld_q && !err_q));
endmodule

// File: rtl/cfgr_ratio_detect.sv
// Configuration stream clock-ratio detector (top).
// Passively monitors a configuration word stream and derives the
// clock-to-data ratio code from two header words and the bus width.
// Assumes start_i is a single-cycle pulse at the head of each image.
module cfgr_ratio_detect
    import cfgr_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ENC_IDX = 69,
    parameter int CMP_IDX = 229,
    parameter int ENC_LSB = 2,
    parameter int ENC_W   = 2,
    parameter int CMP_BIT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              wide_i,
    input  logic              word_vld_i,
    input  logic [DATA_W-1:0] word_i,
    input  logic              end_i,
    output logic [1:0]        ratio_o,
    output logic              ratio_vld_o,
    output logic              short_err_o
);
    logic   hit_enc;
    logic   hit_cmp;
    logic   early_end;
    logic   enc_flag;
    logic   cmp_now;
    logic   wide_img;
    ratio_e code;

    cfgr_word_index #(.ENC_IDX(ENC_IDX), .CMP_IDX(CMP_IDX)) u_index (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .word_vld_i(word_vld_i),
        .end_i(end_i), .hit_enc_o(hit_enc), .hit_cmp_o(hit_cmp),
        .early_end_o(early_end)
    );

    cfgr_field_capture #(.DATA_W(DATA_W), .ENC_LSB(ENC_LSB), .ENC_W(ENC_W),
                         .CMP_BIT(CMP_BIT)) u_capture (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .hit_enc_i(hit_enc), .word_i(word_i), .enc_o(enc_flag),
        .cmp_now_o(cmp_now), .wide_o(wide_img)
    );

    cfgr_ratio_encode u_encode (
        .enc_i(enc_flag), .cmp_i(cmp_now), .wide_i(wide_img), .code_o(code)
    );

    cfgr_result u_result (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .hit_cmp_i(hit_cmp),
        .early_end_i(early_end), .code_i(code), .ratio_o(ratio_o),
        .vld_o(ratio_vld_o), .err_o(short_err_o)
    );

    assert_narrow_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_vld_o && !wide_img) |-> (ratio_o != 2'd3));
    assert_wide_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_vld_o && wide_img) |-> (ratio_o != 2'd1));
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!ratio_vld_o && !short_err_o && ratio_o == 2'd0));
endmodule

// File: tb/cfgr_ratio_detect_tb_top.sv
module cfgr_ratio_detect_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ENC_IDX    = 69;
    localparam int CMP_IDX    = 229;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        wide_i = 1'b0;
    logic        word_vld_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        end_i = 1'b0;
    logic [1:0]  ratio_o;
    logic        ratio_vld_o;
    logic        short_err_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfgr_ratio_detect dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .wide_i(wide_i),
        .word_vld_i(word_vld_i), .word_i(word_i), .end_i(end_i),
        .ratio_o(ratio_o), .ratio_vld_o(ratio_vld_o), .short_err_o(short_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected code from the requirement tables.
    function automatic int exp_code(input bit wide, input bit enc, input bit cmp);
        int b;
        b = cmp ? 2 : (enc ? 1 : 0);
        if (wide && b != 0) b = b + 1;
        return b;
    endfunction

    // Word content: header words carry the fields, others carry decoys.
    function automatic logic [31:0] make_word(input int i, input logic [1:0] encf,
                                              input logic cmpbit);
        logic [31:0] w;
        w = 32'h5A00_0000 ^ (i * 32'h0001_0301);
        if (i == ENC_IDX) begin
            w[3:2] = encf;
        end else if (i == CMP_IDX) begin
            w[1] = cmpbit;
        end else begin
            w[3:2] = (encf == 2'b00) ? 2'b11 : 2'b00;
            w[1]   = ~cmpbit;
        end
        return w;
    endfunction

    task automatic run_image(input bit wide, input logic [1:0] encf,
                             input logic cmpbit, input int nwords,
                             input bit do_end, input bit gaps,
                             input bit flip_wide, input bit end_on_last);
        @(negedge clk);
        start_i = 1'b1;
        wide_i  = wide;
        word_vld_i = 1'b1;            // ignored in the start cycle (R2)
        word_i  = make_word(CMP_IDX, 2'b11, 1'b0);
        @(negedge clk);
        start_i = 1'b0;
        word_vld_i = 1'b0;
        chk("R2 start clears valid", int'(ratio_vld_o), 0);
        for (int i = 0; i < nwords; i++) begin
            if (gaps && (i % 7) == 3) begin
                word_vld_i = 1'b0;
                @(negedge clk);
            end
            if (i == CMP_IDX)
                chk("R7 no valid before word 229", int'(ratio_vld_o), 0);
            if (flip_wide && i == 100)
                wide_i = ~wide;
            word_vld_i = 1'b1;
            word_i = make_word(i, encf, cmpbit);
            end_i  = end_on_last && (i == nwords - 1);
            @(negedge clk);
        end
        word_vld_i = 1'b0;
        end_i = do_end && !end_on_last;
        @(negedge clk);
        end_i = 1'b0;
        wide_i = wide;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset valid", int'(ratio_vld_o), 0);
        chk("R1 reset error", int'(short_err_o), 0);
        chk("R1 reset ratio", int'(ratio_o), 0);
        rst_n = 1'b1;
        // Stream and end while idle: ignored (R1, R9).
        for (int i = 0; i < 240; i++) begin
            @(negedge clk);
            word_vld_i = 1'b1;
            word_i = make_word(i, 2'b01, 1'b0);
        end
        end_i = 1'b1;
        @(negedge clk);
        word_vld_i = 1'b0;
        end_i = 1'b0;
        @(negedge clk);
        chk("R1 idle words ignored", int'(ratio_vld_o), 0);
        chk("R9 idle end ignored", int'(short_err_o), 0);

        // Full sweep: width x encryption field x compression bit (R3-R6, R11).
        for (int w = 0; w < 2; w++)
            for (int e = 0; e < 4; e++)
                for (int c = 0; c < 2; c++) begin
                    run_image(w[0], e[1:0], c[0], CMP_IDX + 1, c[0], (e == 1), 0, 0);
                    chk(w ? "R6 ratio 32-bit" : "R5 ratio 16-bit", int'(ratio_o),
                        exp_code(w[0], e != 0, c == 0));
                    chk("R4 R3 valid after word 229", int'(ratio_vld_o), 1);
                    chk("R9 end after header no error", int'(short_err_o), 0);
                end

        // Long image with trailing words, end later (R7, R9, R11).
        run_image(1, 2'b10, 1'b1, 300, 1, 0, 0, 0);
        chk("R7 ratio holds past header", int'(ratio_o), 2);
        chk("R7 valid holds", int'(ratio_vld_o), 1);
        chk("R9 late end no error", int'(short_err_o), 0);

        // Short image before word 69 (R8).
        run_image(0, 2'b01, 1'b0, 50, 1, 0, 0, 0);
        chk("R8 error before word 69", int'(short_err_o), 1);
        chk("R8 no valid on short image", int'(ratio_vld_o), 0);
        // Short image between the header words, then more traffic (R8).
        run_image(1, 2'b01, 1'b0, 150, 1, 1, 0, 0);
        chk("R8 error between header words", int'(short_err_o), 1);
        for (int i = 0; i < 120; i++) begin
            word_vld_i = 1'b1;
            word_i = make_word(i, 2'b01, 1'b0);
            @(negedge clk);
        end
        word_vld_i = 1'b0;
        @(negedge clk);
        chk("R8 error sticky", int'(short_err_o), 1);
        chk("R8 valid stays low", int'(ratio_vld_o), 0);
        @(negedge clk);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R2 start clears error", int'(short_err_o), 0);

        // Width toggled mid-image (R10).
        run_image(0, 2'b01, 1'b1, CMP_IDX + 1, 0, 0, 1, 0);
        chk("R10 width change ignored (16)", int'(ratio_o), 1);
        run_image(1, 2'b00, 1'b0, CMP_IDX + 1, 0, 0, 1, 0);
        chk("R10 width change ignored (32)", int'(ratio_o), 3);

        // End strobe together with word 229 (R9).
        run_image(1, 2'b01, 1'b1, CMP_IDX + 1, 1, 0, 0, 1);
        chk("R9 end with last header word no error", int'(short_err_o), 0);
        chk("R9 end with last header word valid", int'(ratio_vld_o), 1);
        chk("R6 encryption only 32-bit", int'(ratio_o), 2);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule